// File: doc/BRIEF.md
# Control-Word Four-Bit ALU

This block is a clocked arithmetic logic unit for two small unsigned operands. Each clock it captures operand A, operand B and a packed control word into input registers. From those registered values it computes a sum, a difference, a product, five bitwise results, a circular rotation of A and the contents of a one-shot shift register. The control word picks one of these for a registered result port. The full-width product, a carry flag and three magnitude flags are registered beside the result on every clock.

The control word has four fields. Bits 1:0 set the rotate amount. Bit 2 triggers the shift register. Bits 4:3 select the arithmetic operation. Bits 7:5 select the output source. Shifting does not start from an opcode. A rise of the trigger bit loads A into the shift register, and the fall that follows starts the shift. A host steers the unit by rewriting the control word from cycle to cycle, and it can pulse the trigger while the output source shows the shifter.

Top module: `ctl_word_alu`

## Requirements
- R1: Inputs pass through one input register stage. The registered outputs (result, carry, product, flags) change on the next rising edge. A value presented before edge k is therefore reflected at the outputs after edge k+1, and the outputs update on every rising edge.
- R2: While the synchronous reset is high, every register is cleared. After it the result, carry and product read 0 and the flags read A equal to B.
- R3: With output source 110, the result is the registered A rotated right circularly by ctl[1:0] positions (0 to 3). The bit leaving bit 0 re-enters at bit 3.
- R4: The first edge at which the registered ctl[2] is 1 after having been 0 loads the registered A into the shift register. This load takes priority over shifting.
- R5: At the first edge at which the registered ctl[2] is 0 after a load, the shift register shifts logically right by one bit, filling with zero. It then shifts by one on every edge until it reaches zero and holds there. It holds its value when no trigger edge occurs. Output source 111 shows it.
- R6: Arithmetic code 00 (ctl[4:3]) with output source 000 gives the low 4 bits of A+B, and the carry flag gives bit 4 of that sum.
- R7: Arithmetic code 10 computes A plus the inverted B plus a carry-in of 1 on the same adder. Source 000 gives the low 4 bits, and the carry flag is that adder's carry out (1 when A >= B).
- R8: The product port always gives the 8-bit unsigned product of the registered operands. Arithmetic code 01 with source 000 puts its low 4 bits on the result, with carry 0.
- R9: Arithmetic code 11 gives neither product nor difference. Source 000 then reads 0, and the carry flag is 0.
- R10: Output sources 001, 010, 011, 100 and 101 give A AND B, A OR B, A XOR B, NOT A and NOT B respectively.
- R11: Exactly one of the equal, less-than and greater-than flags is high. They give the unsigned comparison of the registered operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Operand A |
| b_in | input | W | Operand B |
| ctl_in | input | RW+6 | Control word: rotate amount, shift trigger, arithmetic code, output source (low to high) |
| result | output | W | Registered selected result |
| carry | output | 1 | Registered carry out of add or subtract |
| product | output | 2W | Registered full product |
| a_eq_b | output | 1 | Registered flag, A equals B |
| a_lt_b | output | 1 | Registered flag, A below B |
| a_gt_b | output | 1 | Registered flag, A above B |

## Verification
The bench builds the block with its default width of 4. At that width all 256 operand pairs can be swept under every arithmetic code, every output source and varying rotate amounts in a few thousand cycles, so carries, borrows, the largest product and every flag outcome are covered. Directed trigger sequences cover the rest of the shifter: loading, shifting to zero, holding, a one-cycle-high trigger and a reload in the middle of a shift.

// File: rtl/ctl_alu_pkg.sv
package ctl_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_MUL  = 2'b01,
        OP_SUB  = 2'b10,
        OP_NONE = 2'b11
    } arith_op_e;

    typedef enum logic [2:0] {
        SRC_ARITH = 3'b000,
        SRC_AND   = 3'b001,
        SRC_OR    = 3'b010,
        SRC_XOR   = 3'b011,
        SRC_NOTA  = 3'b100,
        SRC_NOTB  = 3'b101,
        SRC_ROT   = 3'b110,
        SRC_SHIFT = 3'b111
    } out_src_e;

    typedef enum logic [1:0] {
        SH_IDLE   = 2'b00,
        SH_LOADED = 2'b01,
        SH_RUN    = 2'b10
    } shift_state_e;

endpackage

// File: rtl/alu_rotator.sv
module alu_rotator #(
    parameter int W     = 4,
    parameter int RW    = 2,
    parameter bit RIGHT = 1'b1
) (
    input  logic [W-1:0]  din,
    input  logic [RW-1:0] amt,
    output logic [W-1:0]  dout
);
    localparam int DW = 2 * W;

    logic [DW-1:0] doubled;
    logic [DW-1:0] moved;

    assign doubled = {din, din};

    generate
        if (RIGHT) begin : g_right
            assign moved = doubled >> amt;
            assign dout  = moved[W-1:0];
        end else begin : g_left
            assign moved = doubled << amt;
            assign dout  = moved[DW-1:W];
        end
    endgenerate

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] b_eff;
    logic [W:0]   total;

    assign b_eff = b ^ {W{sub}};
    assign total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    assign sum   = total[W-1:0];
    assign cout  = total[W];

endmodule

// File: rtl/alu_split_mult.sv
module alu_split_mult #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int HALF = W / 2;
    localparam int PW   = 2 * W;
    localparam int NPP  = 4;

    logic [W-1:0] pp [NPP];

    genvar gi, gj;
    generate
        for (gi = 0; gi < 2; gi++) begin : g_ah
            for (gj = 0; gj < 2; gj++) begin : g_bh
                assign pp[gi*2+gj] = {{HALF{1'b0}}, a[gi*HALF +: HALF]}
                                   * {{HALF{1'b0}}, b[gj*HALF +: HALF]};
            end
        end
    endgenerate

    always_comb begin
        prod = '0;
        for (int k = 0; k < NPP; k++) begin
            prod = prod + ({{W{1'b0}}, pp[k]} << (((k / 2) + (k % 2)) * HALF));
        end
    end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import ctl_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         trig,
    input  logic [W-1:0] din,
    output logic [W-1:0] sr
);
    typedef struct packed {
        shift_state_e state;
        logic         prev;
        logic [W-1:0] sr;
    } sh_t;

    sh_t sh_d, sh_q;
    logic rise, fall;

    assign rise = trig && !sh_q.prev;
    assign fall = !trig && sh_q.prev;

    always_comb begin
        sh_d      = sh_q;
        sh_d.prev = trig;
        if (rise) begin
            sh_d.sr    = din;
            sh_d.state = SH_LOADED;
        end else if (fall && sh_q.state == SH_LOADED) begin
            sh_d.sr    = sh_q.sr >> 1;
            sh_d.state = SH_RUN;
        end else if (sh_q.state == SH_RUN) begin
            sh_d.sr = sh_q.sr >> 1;
            if (sh_d.sr == '0) begin
                sh_d.state = SH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sr = sh_q.sr;

    // R4: a trigger rise loads the operand on the next edge
    p_shift_load_r4: assert property (@(posedge clk) disable iff (rst)
        (trig && !sh_q.prev) |=> (sr == $past(din)));

    // R5: once empty, the register stays empty until a new load
    p_shift_zero_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (sr == '0 && !(trig && !sh_q.prev)) |=> (sr == '0));

    // R5: with no trigger edge and nothing running, contents hold
    p_shift_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (sh_q.state == SH_IDLE && trig == sh_q.prev) |=> $stable(sr));

endmodule

// File: rtl/ctl_word_alu.sv
module ctl_word_alu
    import ctl_alu_pkg::*;
#(
    parameter  int W     = 4,
    localparam int RW    = $clog2(W),
    localparam int CTL_W = RW + 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     a_in,
    input  logic [W-1:0]     b_in,
    input  logic [CTL_W-1:0] ctl_in,
    output logic [W-1:0]     result,
    output logic             carry,
    output logic [2*W-1:0]   product,
    output logic             a_eq_b,
    output logic             a_lt_b,
    output logic             a_gt_b
);
    localparam int PW       = 2 * W;
    localparam int TRIG_BIT = RW;
    localparam int OP_LO    = RW + 1;
    localparam int SEL_LO   = RW + 3;

    typedef struct packed {
        logic [W-1:0]     a;
        logic [W-1:0]     b;
        logic [CTL_W-1:0] ctl;
        logic [W-1:0]     res;
        logic             cy;
        logic [PW-1:0]    prod;
        logic             eq;
        logic             lt;
        logic             gt;
    } st_t;

    st_t q, d;

    arith_op_e    op;
    out_src_e     src;
    logic [RW-1:0] rot_amt;
    logic          trig;

    logic [W-1:0]  as_sum;
    logic          as_cout;
    logic [PW-1:0] mul_p;
    logic [W-1:0]  rot_a;
    logic [W-1:0]  shreg;
    logic [W-1:0]  arith_res;
    logic          arith_cy;

    assign op      = arith_op_e'(q.ctl[OP_LO +: 2]);
    assign src     = out_src_e'(q.ctl[SEL_LO +: 3]);
    assign rot_amt = q.ctl[RW-1:0];
    assign trig    = q.ctl[TRIG_BIT];

    alu_addsub #(.W(W)) i_addsub (
        .a    (q.a),
        .b    (q.b),
        .sub  (op == OP_SUB),
        .sum  (as_sum),
        .cout (as_cout)
    );

    alu_split_mult #(.W(W)) i_mult (
        .a    (q.a),
        .b    (q.b),
        .prod (mul_p)
    );

    alu_rotator #(.W(W), .RW(RW), .RIGHT(1'b1)) i_rot (
        .din  (q.a),
        .amt  (rot_amt),
        .dout (rot_a)
    );

    alu_shift_unit #(.W(W)) i_shift (
        .clk  (clk),
        .rst  (rst),
        .trig (trig),
        .din  (q.a),
        .sr   (shreg)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_SUB: begin
                arith_res = as_sum;
                arith_cy  = as_cout;
            end
            OP_MUL: begin
                arith_res = mul_p[W-1:0];
                arith_cy  = 1'b0;
            end
            default: begin
                arith_res = '0;
                arith_cy  = 1'b0;
            end
        endcase
    end

    always_comb begin
        d      = q;
        d.a    = a_in;
        d.b    = b_in;
        d.ctl  = ctl_in;
        case (src)
            SRC_ARITH: d.res = arith_res;
            SRC_AND:   d.res = q.a & q.b;
            SRC_OR:    d.res = q.a | q.b;
            SRC_XOR:   d.res = q.a ^ q.b;
            SRC_NOTA:  d.res = ~q.a;
            SRC_NOTB:  d.res = ~q.b;
            SRC_ROT:   d.res = rot_a;
            default:   d.res = shreg;
        endcase
        d.cy   = arith_cy;
        d.prod = mul_p;
        d.eq   = (q.a == q.b);
        d.lt   = (q.a <  q.b);
        d.gt   = (q.a >  q.b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.eq <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign result  = q.res;
    assign carry   = q.cy;
    assign product = q.prod;
    assign a_eq_b  = q.eq;
    assign a_lt_b  = q.lt;
    assign a_gt_b  = q.gt;

    // R11: one comparison flag at a time
    p_flags_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot({a_eq_b, a_lt_b, a_gt_b}));

    // R6: add result and carry follow the operands of the previous cycle
    p_add_sum_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD && src == SRC_ARITH)
        |=> ({carry, result} == ({1'b0, $past(q.a)} + {1'b0, $past(q.b)})));

    // R9: unused arithmetic code yields zero and no carry
    p_unused_op_r9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NONE && src == SRC_ARITH) |=> (result == '0 && !carry));

    // R3: rotate by zero passes A through
    p_rot_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_ROT && rot_amt == '0) |=> (result == $past(q.a)));

    // R8: the product port tracks the operands one edge later
    p_product_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (product == ({{W{1'b0}}, $past(q.a)} * {{W{1'b0}}, $past(q.b)})));

endmodule

// File: tb/test_ctl_word_alu.sv
`timescale 1ns/1ps
module test_ctl_word_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a_in = '0;
    logic [3:0] b_in = '0;
    logic [7:0] ctl_in = '0;
    logic [3:0] result;
    logic       carry;
    logic [7:0] product;
    logic       a_eq_b, a_lt_b, a_gt_b;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctl_word_alu i_ctl_word_alu (
        .clk     (clk),
        .rst     (rst),
        .a_in    (a_in),
        .b_in    (b_in),
        .ctl_in  (ctl_in),
        .result  (result),
        .carry   (carry),
        .product (product),
        .a_eq_b  (a_eq_b),
        .a_lt_b  (a_lt_b),
        .a_gt_b  (a_gt_b)
    );

    // behavioural reference model
    int    m_a, m_b, m_ctl, m_sr, m_mode, m_prev;
    int    m_res, m_cy, m_prod, m_flags;
    string m_tag;

    always @(posedge clk) begin
        int op, sel, rot, trig, rv, s, nr;
        string t;
        if (rst) begin
            m_a <= 0; m_b <= 0; m_ctl <= 0; m_sr <= 0; m_mode <= 0; m_prev <= 0;
            m_res <= 0; m_cy <= 0; m_prod <= 0; m_flags <= 4; m_tag <= "R2";
        end else begin
            op   = (m_ctl >> 3) & 3;
            sel  = (m_ctl >> 5) & 7;
            rot  = m_ctl & 3;
            trig = (m_ctl >> 2) & 1;
            rv = 0; s = 0;
            m_cy <= 0;
            t = "R6";
            if (op == 0) begin
                s = m_a + m_b; rv = s & 15; m_cy <= (s >> 4) & 1; t = "R6";
            end else if (op == 2) begin
                s = m_a + ((~m_b) & 15) + 1; rv = s & 15; m_cy <= (s >> 4) & 1; t = "R7";
            end else if (op == 1) begin
                rv = (m_a * m_b) & 15; t = "R8";
            end else begin
                rv = 0; t = "R9";
            end
            case (sel)
                1: begin rv = m_a & m_b; t = "R10"; end
                2: begin rv = m_a | m_b; t = "R10"; end
                3: begin rv = m_a ^ m_b; t = "R10"; end
                4: begin rv = (~m_a) & 15; t = "R10"; end
                5: begin rv = (~m_b) & 15; t = "R10"; end
                6: begin rv = ((m_a >> rot) | (m_a << (4 - rot))) & 15; t = "R3"; end
                7: begin rv = m_sr; t = "R4/R5"; end
                default: ;
            endcase
            m_res  <= rv;
            m_tag  <= t;
            m_prod <= m_a * m_b;
            m_flags <= (m_a == m_b) ? 4 : ((m_a < m_b) ? 2 : 1);
            // shifter
            if (trig == 1 && m_prev == 0) begin
                m_sr <= m_a; m_mode <= 1;
            end else if (trig == 0 && m_prev == 1 && m_mode == 1) begin
                m_sr <= m_sr >> 1; m_mode <= 2;
            end else if (m_mode == 2) begin
                nr = m_sr >> 1;
                m_sr <= nr;
                if (nr == 0) m_mode <= 0;
            end
            m_prev <= trig;
            m_a <= a_in; m_b <= b_in; m_ctl <= ctl_in;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(m_tag, result, m_res);
            chk("R6/R7 carry", carry, m_cy);
            chk("R8 product", product, m_prod);
            chk("R11 flags", {a_eq_b, a_lt_b, a_gt_b}, m_flags);
        end
    end

    task automatic drive(input int a, input int b, input int sel, input int op,
                         input int trig, input int rot);
        @(negedge clk);
        a_in   = a[3:0];
        b_in   = b[3:0];
        ctl_in = {sel[2:0], op[1:0], trig[0], rot[1:0]};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: outputs cleared while reset is held
        chk("R2 result", result, 0);
        chk("R2 carry", carry, 0);
        chk("R2 product", product, 0);
        chk("R2 flags", {a_eq_b, a_lt_b, a_gt_b}, 4);
        cmp_en = 1'b1;
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1: two-edge latency from inputs to result
        a_in = 4'd5; b_in = 4'd3; ctl_in = 8'b000_00_0_00;
        @(negedge clk);
        chk("R1 one edge", result, 0);
        @(negedge clk);
        chk("R1 two edges", result, 8);

        // exhaustive operand sweep over all codes and sources
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int op = 0; op < 4; op++)
                    for (int sel = 0; sel < 8; sel++)
                        drive(a, b, sel, op, 0, (a ^ b ^ sel) & 3);

        // R4 / R5: load, shift to zero, hold
        drive(11, 0, 7, 0, 0, 0);
        drive(11, 0, 7, 0, 1, 0);
        drive(6, 0, 7, 0, 1, 0);
        repeat (6) drive(9, 0, 7, 0, 0, 0);
        @(negedge clk);
        chk("R5 empty after shifting", result, 0);
        // trigger high for exactly one cycle, then reload mid-shift
        drive(15, 0, 7, 0, 1, 0);
        drive(15, 0, 7, 0, 0, 0);
        drive(15, 0, 7, 0, 0, 0);
        drive(12, 0, 7, 0, 1, 0);
        drive(3, 0, 7, 0, 0, 0);
        repeat (3) drive(3, 0, 7, 0, 0, 0);
        // load with no falling edge yet: value holds (R5)
        drive(13, 0, 7, 0, 1, 0);
        repeat (4) drive(0, 0, 7, 0, 1, 0);
        @(negedge clk);
        chk("R4 held load", result, 13);
        repeat (8) drive(0, 0, 7, 0, 0, 0);
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20ns * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule